// File: doc/BRIEF.md
# Zero-Count Checked ALU

This block is a 32-bit ALU stage whose every result is checked while it is produced. Alongside the datapath, a separate prediction unit works out what the zero count of the result should be, modulo 2^K. It decodes the opcode itself and uses only the operand zero counts, the operand edge bits and the adder's carry vector. A generator derives the actual check symbol from the result the datapath emits, and a comparator raises an error on any difference. A single flipped result bit therefore always shows up. Expected symbols are derived algebraically per operation; the datapath is not duplicated.

The stage is run by a small state machine. `start` in state IDLE latches the opcode and operands, and the stage moves to EVAL. The first evaluation then moves the stage to DONE if the symbols agree, or to WAIT if they do not. In WAIT the held operands are evaluated again every cycle. The first clean evaluation moves the stage to DONE. After `WDOG_LIMIT` failing re-evaluations the stage moves to RECOVER instead, issues a one-cycle pipeline reset request, and returns to IDLE. DONE and RECOVER always return to IDLE. The completion pulse is never given while the error is high. A `fault_mask` input flips result bits ahead of the generator, so that transient and persistent faults can be applied.

Top module: `zc_checked_alu`

## Requirements
- R1: After reset, `done`, `err` and `wdog_rst` are low, and `result` and `res_sym` are zero.
- R2: With no fault, the arithmetic opcodes give the wrapped 32-bit result on `result` together with a one-cycle `done` pulse on the second clock edge after `start` is sampled, while `err` stays low. The opcodes are 0 add, 1 subtract (X−Y), 2 increment X and 3 decrement X.
- R3: With no fault, the bitwise opcodes give correct results with `done` and no `err`. The opcodes are 4 AND, 5 OR, 6 XOR, 7 NAND and 8 NOR.
- R4: With no fault, the single-place moves of X give correct results. The opcodes are 9 logical left, 10 logical right, 11 arithmetic left (zero fill), 12 arithmetic right (sign kept), 13 rotate left and 14 rotate right.
- R5: When `done` is high, `res_sym[4:2]` holds the number of zero bits of `result` mod 8, and `res_sym[1:0]` holds the number of zero bits within `res_sym[4:2]`.
- R6: A single-bit flip applied through `fault_mask` at an evaluation edge raises `err` at that edge, and `done` stays low while `err` is high.
- R7: Once the flip is removed, the next evaluation clears `err` and pulses `done` with the correct result. This includes removal at the last allowed re-evaluation.
- R8: If the first evaluation and all `WDOG_LIMIT` re-evaluations fail, `wdog_rst` is high for exactly one cycle, with `err` high and `done` low. On the following cycle all three are low.
- R9: `start` is ignored while an operation is in progress, so operands presented during EVAL or WAIT do not change the result.
- R10: Opcode 15 passes X unchanged to `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept a new operation when idle |
| opcode | input | 4 | Operation select |
| op_x | input | 32 | First operand |
| op_y | input | 32 | Second operand |
| fault_mask | input | 32 | Bits flipped on the datapath output before checking |
| result | output | 32 | Registered result |
| res_sym | output | 5 | Registered check symbol of `result` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Predicted and generated symbols differ |
| wdog_rst | output | 1 | One-cycle pipeline reset request |

## Verification
Operands are latched on the edge that samples `start`. The first evaluation result appears after the next edge: `err` if the symbols disagree, otherwise `done` with `result` and `res_sym`. Each further re-evaluation adds one edge. A run whose mask stays active for m evaluations (m ≤ `WDOG_LIMIT`) completes after edge m+1. A run that keeps failing raises `wdog_rst` after edge `WDOG_LIMIT`+1. The bench drives inputs and samples outputs at falling edges. It steps a behavioural per-cycle expectation in lock step and compares it on every cycle, so each value is checked exactly in the cycle it is due.

// File: rtl/zc_pkg.sv
package zc_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NAND = 4'd7,
        OP_NOR  = 4'd8,
        OP_LSL  = 4'd9,
        OP_LSR  = 4'd10,
        OP_ASL  = 4'd11,
        OP_ASR  = 4'd12,
        OP_ROL  = 4'd13,
        OP_ROR  = 4'd14,
        OP_MOV  = 4'd15
    } zc_op_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_EVAL    = 3'd1,
        S_WAIT    = 3'd2,
        S_DONE    = 3'd3,
        S_RECOVER = 3'd4
    } zc_state_e;

endpackage

// File: rtl/zc_zero_count.sv
module zc_zero_count #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);
    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + CW'(!vec[i]);
        end
    end
endmodule

// File: rtl/zc_datapath.sv
module zc_datapath
    import zc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic [W-1:0] carries
);
    zc_op_e       dec;
    logic [W-1:0] addend;
    logic         cin;
    logic [W:0]   c;
    logic [W-1:0] sum;

    assign dec = zc_op_e'(op);

    // Operand conditioning for the adder (datapath's own decode)
    always_comb begin
        addend = b;
        cin    = 1'b0;
        case (dec)
            OP_SUB: begin addend = ~b; cin = 1'b1; end
            OP_INC: begin addend = '0; cin = 1'b1; end
            OP_DEC: begin addend = '1; cin = 1'b0; end
            default: ;
        endcase
    end

    // Ripple chain so the full carry vector is observable
    assign c[0] = cin;
    generate
        for (genvar i = 0; i < W; i++) begin : g_ripple
            assign sum[i]   = a[i] ^ addend[i] ^ c[i];
            assign c[i+1]   = (a[i] & addend[i]) | (c[i] & (a[i] ^ addend[i]));
        end
    endgenerate
    assign carries = c[W:1];

    always_comb begin
        case (dec)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: res = sum;
            OP_AND:           res = a & b;
            OP_OR:            res = a | b;
            OP_XOR:           res = a ^ b;
            OP_NAND:          res = ~(a & b);
            OP_NOR:           res = ~(a | b);
            OP_LSL, OP_ASL:   res = {a[W-2:0], 1'b0};
            OP_LSR:           res = {1'b0, a[W-1:1]};
            OP_ASR:           res = {a[W-1], a[W-1:1]};
            OP_ROL:           res = {a[W-2:0], a[W-1]};
            OP_ROR:           res = {a[0], a[W-1:1]};
            default:          res = a;
        endcase
    end
endmodule

// File: rtl/zc_predict.sv
module zc_predict
    import zc_pkg::*;
#(
    parameter int W = 32,
    parameter int K = 3
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] carries,
    output logic [K-1:0] c1
);
    localparam int          CW   = $clog2(W + 1);
    localparam logic [K-1:0] NMOD = K'(W);

    zc_op_e        dec;
    logic [CW-1:0] za, zb, z_or, z_and, z_cy;
    logic [K-1:0]  xk, yk, ork, andk, cyk, coutk, msbk, lsbk;

    assign dec = zc_op_e'(op);

    zc_zero_count #(.W(W), .CW(CW)) u_za   (.vec(a),       .zeros(za));
    zc_zero_count #(.W(W), .CW(CW)) u_zb   (.vec(b),       .zeros(zb));
    zc_zero_count #(.W(W), .CW(CW)) u_zor  (.vec(a | b),   .zeros(z_or));
    zc_zero_count #(.W(W), .CW(CW)) u_zand (.vec(a & b),   .zeros(z_and));
    zc_zero_count #(.W(W), .CW(CW)) u_zcy  (.vec(carries), .zeros(z_cy));

    // Only the low K bits matter: everything is taken mod 2^K
    assign xk    = za[K-1:0];
    assign yk    = zb[K-1:0];
    assign ork   = z_or[K-1:0];
    assign andk  = z_and[K-1:0];
    assign cyk   = z_cy[K-1:0];
    assign coutk = K'(carries[W-1]);
    assign msbk  = K'(a[W-1]);
    assign lsbk  = K'(a[0]);

    // Zeros(result) = Xc + Y'c - Cc - cin + cout for the adder,
    // where Y' is the operand actually presented to the adder.
    always_comb begin
        case (dec)
            OP_ADD:  c1 = xk + yk - cyk + coutk;
            OP_SUB:  c1 = xk + (NMOD - yk) - cyk - K'(1) + coutk;
            OP_INC:  c1 = xk + NMOD - cyk - K'(1) + coutk;
            OP_DEC:  c1 = xk - cyk + coutk;
            OP_AND:  c1 = xk + yk - ork;
            OP_OR:   c1 = xk + yk - andk;
            OP_XOR:  c1 = NMOD + xk + yk - (andk << 1);
            OP_NAND: c1 = NMOD - xk - yk + ork;
            OP_NOR:  c1 = NMOD - xk - yk + andk;
            OP_LSL, OP_ASL: c1 = xk + msbk;
            OP_LSR:  c1 = xk + lsbk;
            OP_ASR:  c1 = xk + lsbk - msbk;
            default: c1 = xk;
        endcase
    end
endmodule

// File: rtl/zc_symgen.sv
module zc_symgen #(
    parameter int W    = 32,
    parameter int K    = 3,
    parameter int C2W  = $clog2(K + 1),
    parameter int SYMW = K + C2W
) (
    input  logic [W-1:0]    vec,
    output logic [SYMW-1:0] sym
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0]  zc;
    logic [C2W-1:0] c2;

    zc_zero_count #(.W(W), .CW(CW))  u_data (.vec(vec),       .zeros(zc));
    zc_zero_count #(.W(K), .CW(C2W)) u_chk  (.vec(zc[K-1:0]), .zeros(c2));

    assign sym = {zc[K-1:0], c2};
endmodule

// File: rtl/zc_checked_alu.sv
module zc_checked_alu
    import zc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CHK_K      = 3,
    parameter int WDOG_LIMIT = 6
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      start,
    input  logic [3:0]                                opcode,
    input  logic [DATA_W-1:0]                         op_x,
    input  logic [DATA_W-1:0]                         op_y,
    input  logic [DATA_W-1:0]                         fault_mask,
    output logic [DATA_W-1:0]                         result,
    output logic [CHK_K+$clog2(CHK_K+1)-1:0]          res_sym,
    output logic                                      done,
    output logic                                      err,
    output logic                                      wdog_rst
);
    localparam int C2W   = $clog2(CHK_K + 1);
    localparam int SYMW  = CHK_K + C2W;
    localparam int CNT_W = $clog2(WDOG_LIMIT + 1);

    zc_state_e         state, state_nxt;
    logic [3:0]        op_q;
    logic [DATA_W-1:0] x_q, y_q;
    logic [DATA_W-1:0] dp_res, dp_carries, seen_res;
    logic [CHK_K-1:0]  c1_pred;
    logic [C2W-1:0]    c2_pred;
    logic [SYMW-1:0]   sym_pred, sym_act;
    logic              mismatch;
    logic [CNT_W-1:0]  wait_cnt;
    logic [DATA_W-1:0] res_q;
    logic [SYMW-1:0]   sym_q;
    logic              err_q;
    logic              evaluating;

    // Datapath and predictor decode the held opcode independently
    zc_datapath #(.W(DATA_W)) u_dp (
        .op(op_q), .a(x_q), .b(y_q), .res(dp_res), .carries(dp_carries)
    );

    zc_predict #(.W(DATA_W), .K(CHK_K)) u_pred (
        .op(op_q), .a(x_q), .b(y_q), .carries(dp_carries), .c1(c1_pred)
    );

    zc_zero_count #(.W(CHK_K), .CW(C2W)) u_pred_c2 (
        .vec(c1_pred), .zeros(c2_pred)
    );
    assign sym_pred = {c1_pred, c2_pred};

    // Fault injection sits between datapath and generator
    assign seen_res = dp_res ^ fault_mask;

    zc_symgen #(.W(DATA_W), .K(CHK_K), .C2W(C2W), .SYMW(SYMW)) u_gen (
        .vec(seen_res), .sym(sym_act)
    );

    assign mismatch   = (sym_pred != sym_act);
    assign evaluating = (state == S_EVAL) || (state == S_WAIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:    if (start) state_nxt = S_EVAL;
            S_EVAL:    state_nxt = mismatch ? S_WAIT : S_DONE;
            S_WAIT: begin
                if (!mismatch)
                    state_nxt = S_DONE;
                else if (wait_cnt == CNT_W'(WDOG_LIMIT - 1))
                    state_nxt = S_RECOVER;
            end
            S_DONE:    state_nxt = S_IDLE;
            S_RECOVER: state_nxt = S_IDLE;
            default:   state_nxt = S_IDLE;
        endcase
    end

    // Operand capture, evaluation results and retry counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            x_q      <= '0;
            y_q      <= '0;
            res_q    <= '0;
            sym_q    <= '0;
            err_q    <= 1'b0;
            wait_cnt <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                op_q <= opcode;
                x_q  <= op_x;
                y_q  <= op_y;
            end
            if (evaluating) begin
                res_q <= seen_res;
                sym_q <= sym_act;
                err_q <= mismatch;
            end else if (state == S_RECOVER) begin
                err_q <= 1'b0;
            end
            if (state == S_EVAL)
                wait_cnt <= '0;
            else if (state == S_WAIT && mismatch)
                wait_cnt <= wait_cnt + CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        result   = res_q;
        res_sym  = sym_q;
        err      = err_q;
        done     = (state == S_DONE);
        wdog_rst = (state == S_RECOVER);
    end
endmodule

// File: rtl/zc_checked_alu_chk.sv
module zc_checked_alu_chk #(
    parameter int DATA_W = 32,
    parameter int CHK_K  = 3,
    parameter int SYMW   = CHK_K + $clog2(CHK_K + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] result,
    input logic [SYMW-1:0]   res_sym,
    input logic              done,
    input logic              err,
    input logic              wdog_rst
);
    // Completion is withheld while the error is raised
    assert_done_withheld_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);

    // A completion pulse lasts one cycle
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Watchdog request lasts one cycle and leaves the stage quiet
    assert_wdog_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> (!wdog_rst && !err && !done));

    // Watchdog fires only with the error still raised
    assert_wdog_with_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> err);

    // A completed result carries a consistent zero count in its symbol
    assert_sym_consistent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_sym[SYMW-1 -: CHK_K] == CHK_K'($countones(~result))));

    // A new error can only appear on the first evaluation of an accepted start
    assert_err_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(start, 2));
endmodule

bind zc_checked_alu zc_checked_alu_chk #(
    .DATA_W(DATA_W), .CHK_K(CHK_K)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .result(result),
    .res_sym(res_sym), .done(done), .err(err), .wdog_rst(wdog_rst)
);

// File: tb/zc_checked_alu_test.sv
`timescale 1ns/1ps
module zc_checked_alu_test;
    localparam int W   = 32;
    localparam int K   = 3;
    localparam int LIM = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   opcode = '0;
    logic [W-1:0] op_x = '0, op_y = '0, fault_mask = '0;
    logic [W-1:0] result;
    logic [4:0]   res_sym;
    logic         done, err, wdog_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    zc_checked_alu #(.DATA_W(W), .CHK_K(K), .WDOG_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_x(op_x), .op_y(op_y), .fault_mask(fault_mask),
        .result(result), .res_sym(res_sym), .done(done), .err(err),
        .wdog_rst(wdog_rst)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_res(input logic [3:0] op,
                                             input logic [W-1:0] x, input logic [W-1:0] y);
        case (op)
            4'd0:  return x + y;
            4'd1:  return x - y;
            4'd2:  return x + 1;
            4'd3:  return x - 1;
            4'd4:  return x & y;
            4'd5:  return x | y;
            4'd6:  return x ^ y;
            4'd7:  return ~(x & y);
            4'd8:  return ~(x | y);
            4'd9:  return x << 1;
            4'd10: return x >> 1;
            4'd11: return x << 1;
            4'd12: return W'($signed(x) >>> 1);
            4'd13: return {x[W-2:0], x[W-1]};
            4'd14: return {x[0], x[W-1:1]};
            default: return x;
        endcase
    endfunction

    function automatic logic [4:0] ref_sym(input logic [W-1:0] r);
        int z = 0;
        int z2 = 0;
        logic [2:0] c1;
        for (int i = 0; i < W; i++) if (!r[i]) z++;
        c1 = 3'(z % 8);
        for (int i = 0; i < 3; i++) if (!c1[i]) z2++;
        return {c1, 2'(z2)};
    endfunction

    // Run one operation; the mask is applied on the first m evaluations.
    task automatic run_op(input logic [3:0] op, input logic [W-1:0] x,
                          input logic [W-1:0] y, input logic [W-1:0] mask,
                          input int m, input bit junk, input string req);
        logic [W-1:0] exp_r;
        exp_r = ref_res(op, x, y);
        @(negedge clk);
        start = 1'b1; opcode = op; op_x = x; op_y = y; fault_mask = '0;
        @(negedge clk);
        start = junk;
        if (junk) begin op_x = ~x; op_y = x; opcode = ~op; end
        chk(!done && !err && !wdog_rst, req, {done, err, wdog_rst}, 0);
        for (int j = 1; j <= LIM + 2; j++) begin
            fault_mask = (j <= m) ? mask : '0;
            @(negedge clk);
            if (j <= m && j <= LIM) begin
                chk(err && !done && !wdog_rst, "R6 err raised, done withheld",
                    {done, err, wdog_rst}, 3'b010);
            end else if (j <= m) begin
                chk(wdog_rst && err && !done, "R8 watchdog request",
                    {done, err, wdog_rst}, 3'b011);
                fault_mask = '0; start = 1'b0;
                @(negedge clk);
                chk(!wdog_rst && !err && !done, "R8 quiet after watchdog",
                    {done, err, wdog_rst}, 3'b000);
                break;
            end else begin
                start = 1'b0;
                chk(done && !err && !wdog_rst, (m > 0) ? "R7 recovery completes" : req,
                    {done, err, wdog_rst}, 3'b100);
                chk(result == exp_r, junk ? "R9 result unaffected by start" : req,
                    result, exp_r);
                chk(res_sym == ref_sym(exp_r), "R5 result symbol", res_sym, ref_sym(exp_r));
                @(negedge clk);
                chk(!done, "R2 single done pulse", done, 0);
                break;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!done && !err && !wdog_rst, "R1 flags after reset", {done, err, wdog_rst}, 0);
        chk(result == '0, "R1 result after reset", result, 0);
        chk(res_sym == '0, "R1 symbol after reset", res_sym, 0);

        // R2 arithmetic, including wrap corners
        run_op(4'd0, 32'hFFFF_FFFF, 32'h1, '0, 0, 0, "R2 add wrap");
        run_op(4'd0, 32'h1234_5678, 32'h0F0F_F0F0, '0, 0, 0, "R2 add");
        run_op(4'd1, 32'h5, 32'h9, '0, 0, 0, "R2 sub borrow");
        run_op(4'd1, 32'h0, 32'h0, '0, 0, 0, "R2 sub zero");
        run_op(4'd2, 32'hFFFF_FFFF, 32'h0, '0, 0, 0, "R2 inc wrap");
        run_op(4'd3, 32'h0, 32'h0, '0, 0, 0, "R2 dec wrap");
        // R3 bitwise
        run_op(4'd4, 32'hF0F0_1234, 32'hFF00_FF0F, '0, 0, 0, "R3 and");
        run_op(4'd5, 32'h0000_0001, 32'h8000_0000, '0, 0, 0, "R3 or");
        run_op(4'd6, 32'hAAAA_5555, 32'hFFFF_0000, '0, 0, 0, "R3 xor");
        run_op(4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, 0, 0, "R3 nand");
        run_op(4'd8, 32'h0, 32'h0, '0, 0, 0, "R3 nor");
        // R4 moves with edge bits set
        run_op(4'd9,  32'h8000_0001, '0, '0, 0, 0, "R4 lsl");
        run_op(4'd10, 32'h8000_0001, '0, '0, 0, 0, "R4 lsr");
        run_op(4'd11, 32'h8000_0000, '0, '0, 0, 0, "R4 asl");
        run_op(4'd12, 32'h8000_0010, '0, '0, 0, 0, "R4 asr negative");
        run_op(4'd12, 32'h4000_0001, '0, '0, 0, 0, "R4 asr positive");
        run_op(4'd13, 32'h8000_0000, '0, '0, 0, 0, "R4 rol");
        run_op(4'd14, 32'h0000_0001, '0, '0, 0, 0, "R4 ror");
        // R10 pass-through
        run_op(4'd15, 32'hDEAD_BEEF, 32'h1, '0, 0, 0, "R10 pass");
        // Sweep of every opcode over computed operand patterns
        s = 32'h1357_9BDF;
        for (int p = 0; p < 6; p++) begin
            for (int op = 0; op < 16; op++) begin
                run_op(4'(op), s, {s[15:0], s[31:16]} ^ 32'h5A5A_0F0F, '0, 0, 0,
                       (op < 4) ? "R2 sweep" : (op < 9) ? "R3 sweep" :
                       (op < 15) ? "R4 sweep" : "R10 sweep");
            end
            s = s * 32'd1103515245 + 32'd12345;
        end
        // R6 / R7 transient faults
        run_op(4'd0, 32'h0000_00FF, 32'h1, 32'h1, 1, 0, "R6 flip bit0");
        run_op(4'd6, 32'hFFFF_0000, 32'h1234_5678, 32'h8000_0000, 3, 0, "R7 flip bit31");
        run_op(4'd1, 32'h7, 32'h3, 32'h0002_0000, LIM, 0, "R7 last allowed retry");
        // R8 persistent fault, then normal operation resumes
        run_op(4'd4, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0000_0100, LIM + 1, 0, "R8 persistent");
        run_op(4'd0, 32'h10, 32'h20, '0, 0, 0, "R8 operation after watchdog");
        // R9 start ignored while busy
        run_op(4'd5, 32'h00FF_0000, 32'h0000_00FF, 32'h4, 2, 1, "R9 start while waiting");
        run_op(4'd2, 32'h41, 32'h0, '0, 0, 1, "R9 start during evaluation");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule